// File: doc/BRIEF.md
# Power-Fail Guarded Two-Wire Register Slave

This block is the bus front end of a battery-backed register device. It watches a two-wire serial bus (SCL clock, SDA data), finds start and stop conditions, answers its own 7-bit device address, and moves bytes between the bus and an external register file through an internal pointer. Writes set the pointer with their first data byte and store the following bytes at consecutive locations. Reads stream bytes from the current pointer onward. SDA is only ever pulled low through an output enable. The pad and the pull-up turn that into an open-drain line.

A supply sequencer sits beside the bus logic. Two flags from external comparators feed it. One says the supply is below the power-fail threshold. The other says the supply is below the battery voltage. A power fail kills the transfer in progress, returns the pointer to zero and closes the bus. The bus opens again only after the supply has been good for a programmable number of clock cycles; 40000 cycles is 200 µs at 200 MHz. The battery flag moves the supply-select output to battery and raises a low-power indication. All four bus and supply inputs pass through two-flop synchronizers.

The register side is a plain port. `reg_rdata` must show the contents of `reg_addr` in the same cycle. The register file must take a write in any cycle where `reg_we` is high. The bus cannot be held off, so there is no back-pressure on this port.

Top module: `pf_serial_slave`

## Requirements
- R1: A high-to-low SDA change while SCL is high is a start, and a low-to-high change is a stop. Bus traffic is only interpreted after a start. Bits clocked after a stop without a new start write nothing and draw no acknowledge.
- R2: SDA is sampled on the SCL rising edge. Bytes move most significant bit first. The ninth clock of every byte is the acknowledge slot, where a low level means acknowledge.
- R3: The first byte after a start holds a 7-bit device address in bits 7..1 and the direction in bit 0 (1 = read). Only DEV_ADDR is acknowledged. Any other address gets no acknowledge, and the block stays silent and writes nothing until the next start.
- R4: In a write, the first byte after the address loads the pointer with its low ADDR_W bits and is acknowledged. Each later byte is written at the pointer, acknowledged, and then the pointer steps by one, wrapping from 2^ADDR_W-1 to 0.
- R5: In a read, bytes come from the pointer, which steps by one (wrapping) after each byte. A master acknowledge continues the read. A master no-acknowledge releases SDA until the next start.
- R6: Within three clocks of the power-fail flag rising, the transfer ends, SDA is released and the pointer is zero. A later read without a pointer byte starts at location 0.
- R7: While the power-fail flag is high, and during the recovery interval after it, SCL and SDA are ignored: no acknowledge and no register write.
- R8: The bus is accepted again only after the power-fail flag has been low for RECOVERY_CYCLES consecutive clocks. A re-assertion restarts the count. The same interval applies after reset.
- R9: `sel_bat` follows the below-battery flag with a three-cycle delay. `low_pwr` is high when both flags were high three cycles earlier. Both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When high the pad pulls SDA low |
| vlow_i | input | 1 | Supply below power-fail threshold |
| vbat_i | input | 1 | Supply below battery voltage |
| sel_bat | output | 1 | Supply source: 1 = battery, 0 = main |
| low_pwr | output | 1 | Low-power mode indication |
| reg_addr | output | ADDR_W | Register pointer, used for reads and writes |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Contents of the location at reg_addr |

## Verification
Write bursts that cross the top location show pointer loading, auto-increment and wrap. A read after a repeated start shows that the pointer survives the restart. The read ends with a master no-acknowledge, which separates "continue" from "release". A foreign address and bare clocking after a stop show that only a matching address after a real start is served. A power fail in the middle of a byte, bus traffic while the flag is high, and a short flag pulse inside the recovery window separate "abort and reset pointer" from "merely pause", and "restart the recovery count" from "accumulate it". The flag histories are compared against the supply outputs on every clock.

// File: rtl/pfs_pkg.sv
`timescale 1ns/1ps
package pfs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_DEV,
    LK_DEV_ACK,
    LK_RX,
    LK_RX_ACK,
    LK_TX,
    LK_TX_ACK
  } link_state_t;
endpackage

// File: rtl/pfs_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer with a per-bit reset value.
module pfs_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pfs_power_seq.sv
`timescale 1ns/1ps
// Supply sequencer: recovery timer gating the bus, and supply-source select.
module pfs_power_seq #(
  parameter int RECOVERY_CYCLES = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vlow_s,
  input  logic vbat_s,
  output logic bus_en,
  output logic sel_bat,
  output logic low_pwr
);
  localparam int CW = $clog2(RECOVERY_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RECOVERY_CYCLES);

  logic [CW-1:0] good_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                good_cnt <= '0;
    else if (vlow_s)           good_cnt <= '0;
    else if (good_cnt != LIMIT) good_cnt <= good_cnt + 1'b1;
  end

  assign bus_en = (good_cnt == LIMIT) && !vlow_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_bat <= 1'b0;
      low_pwr <= 1'b0;
    end else begin
      sel_bat <= vbat_s;
      low_pwr <= vbat_s & vlow_s;
    end
  end
endmodule

// File: rtl/pfs_link.sv
`timescale 1ns/1ps
// Two-wire slave protocol engine working on synchronized line levels.
module pfs_link
  import pfs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              bus_en,
  input  logic              abort,
  input  logic [BYTE_W-1:0] rdata,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] ptr,
  output logic [BYTE_W-1:0] wdata,
  output logic              we
);
  localparam logic [3:0] FULL = 4'(BYTE_W);

  link_state_t       state;
  logic              p_scl, p_sda;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic              rw, first, nack, oe;
  logic              start_c, stop_c, rise, fall, byte_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_scl <= 1'b1;
      p_sda <= 1'b1;
    end else begin
      p_scl <= scl_s;
      p_sda <= sda_s;
    end
  end

  assign start_c   = bus_en & p_scl & scl_s & p_sda & ~sda_s;
  assign stop_c    = bus_en & p_scl & scl_s & ~p_sda & sda_s;
  assign rise      = bus_en & ~p_scl & scl_s;
  assign fall      = bus_en & p_scl & ~scl_s;
  assign byte_done = (bitcnt == FULL);

  assign we     = (state == LK_RX) & fall & byte_done & ~first;
  assign wdata  = shreg;
  assign sda_oe = oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= LK_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      rw     <= 1'b0;
      first  <= 1'b0;
      nack   <= 1'b0;
      oe     <= 1'b0;
      ptr    <= '0;
    end else if (abort) begin
      state  <= LK_IDLE;
      bitcnt <= '0;
      oe     <= 1'b0;
      ptr    <= '0;
    end else if (!bus_en) begin
      state  <= LK_IDLE;
      oe     <= 1'b0;
    end else if (start_c) begin
      state  <= LK_DEV;
      bitcnt <= '0;
      oe     <= 1'b0;
    end else if (stop_c) begin
      state  <= LK_IDLE;
      oe     <= 1'b0;
    end else begin
      unique case (state)
        LK_DEV, LK_RX: begin
          if (rise) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (fall && byte_done) begin
            bitcnt <= '0;
            if (state == LK_DEV) begin
              if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                oe    <= 1'b1;
                rw    <= shreg[0];
                state <= LK_DEV_ACK;
              end else begin
                state <= LK_IDLE;
              end
            end else begin
              oe    <= 1'b1;
              state <= LK_RX_ACK;
              if (first) begin
                ptr   <= shreg[ADDR_W-1:0];
                first <= 1'b0;
              end else begin
                ptr <= ptr + 1'b1;
              end
            end
          end
        end
        LK_DEV_ACK: begin
          if (fall) begin
            if (rw) begin
              shreg <= rdata;
              oe    <= ~rdata[BYTE_W-1];
              state <= LK_TX;
            end else begin
              oe    <= 1'b0;
              first <= 1'b1;
              state <= LK_RX;
            end
          end
        end
        LK_RX_ACK: begin
          if (fall) begin
            oe    <= 1'b0;
            state <= LK_RX;
          end
        end
        LK_TX: begin
          if (rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (fall) begin
            if (byte_done) begin
              oe     <= 1'b0;
              bitcnt <= '0;
              ptr    <= ptr + 1'b1;
              state  <= LK_TX_ACK;
            end else begin
              shreg <= shreg << 1;
              oe    <= ~shreg[BYTE_W-2];
            end
          end
        end
        LK_TX_ACK: begin
          if (rise) begin
            nack <= sda_s;
          end else if (fall) begin
            if (nack) begin
              state <= LK_IDLE;
            end else begin
              shreg <= rdata;
              oe    <= ~rdata[BYTE_W-1];
              state <= LK_TX;
            end
          end
        end
        default: state <= LK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pf_serial_slave.sv
`timescale 1ns/1ps
// Top: synchronizers, supply sequencer and protocol engine.
module pf_serial_slave
  import pfs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int ADDR_W = 6,
  parameter int RECOVERY_CYCLES = 40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              vlow_i,
  input  logic              vbat_i,
  output logic              sel_bat,
  output logic              low_pwr,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int NIN = 4;
  // lines idle high, power-fail assumed until sampled, battery flag low
  localparam logic [NIN-1:0] IN_RST = 4'b0111;

  logic [NIN-1:0] raw_in, sync_in;
  logic           scl_s, sda_s, vlow_s, vbat_s, bus_en;

  assign raw_in = {vbat_i, vlow_i, sda_i, scl_i};
  assign {vbat_s, vlow_s, sda_s, scl_s} = sync_in;

  pfs_sync #(.W(NIN), .RST_VAL(IN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_in)
  );

  pfs_power_seq #(.RECOVERY_CYCLES(RECOVERY_CYCLES)) u_pwr (
    .clk(clk), .rst_n(rst_n), .vlow_s(vlow_s), .vbat_s(vbat_s),
    .bus_en(bus_en), .sel_bat(sel_bat), .low_pwr(low_pwr)
  );

  pfs_link #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .bus_en(bus_en), .abort(vlow_s), .rdata(reg_rdata),
    .sda_oe(sda_oe), .ptr(reg_addr), .wdata(reg_wdata), .we(reg_we)
  );
endmodule

// File: rtl/pfs_checker.sv
`timescale 1ns/1ps
module pfs_checker #(
  parameter int ADDR_W = 6,
  parameter int RECOVERY_CYCLES = 40000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vlow_s,
  input logic              bus_en,
  input logic              sda_oe,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              sel_bat,
  input logic              vbat_i
);
  logic [31:0] quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              quiet <= '0;
    else if (vlow_s)                         quiet <= '0;
    else if (quiet < 32'(RECOVERY_CYCLES))   quiet <= quiet + 1'b1;
  end

  assert_abort_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vlow_s |=> (!sda_oe && reg_addr == '0));

  assert_locked_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> !sda_oe);

  assert_recovery_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> (quiet >= 32'(RECOVERY_CYCLES)));

  assert_drive_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> $past(bus_en));

  assert_battery_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_bat) |-> $past(vbat_i, 3));
endmodule

bind pf_serial_slave pfs_checker #(.ADDR_W(ADDR_W), .RECOVERY_CYCLES(RECOVERY_CYCLES)) u_pfs_checker (
  .clk(clk), .rst_n(rst_n), .vlow_s(vlow_s), .bus_en(bus_en), .sda_oe(sda_oe),
  .reg_addr(reg_addr), .sel_bat(sel_bat), .vbat_i(vbat_i)
);

// File: tb/test_pf_serial_slave.sv
`timescale 1ns/1ps
module test_pf_serial_slave;
  localparam logic [6:0] DEV = 7'h51;
  localparam int AW = 3;
  localparam int NR = 1 << AW;
  localparam int RC = 64;
  localparam int Q  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, vlow = 1'b0, vbat = 1'b0;
  logic sda_oe, sel_bat, low_pwr, reg_we, sda_line;
  logic [AW-1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [NR];
  logic [7:0] exp_mem [NR];
  int vectors = 0, fails = 0;
  bit done = 1'b0;
  bit vb_q[$], vl_q[$];

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  pf_serial_slave #(.DEV_ADDR(DEV), .ADDR_W(AW), .RECOVERY_CYCLES(RC)) i_pf_serial_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .vlow_i(vlow), .vbat_i(vbat), .sel_bat(sel_bat), .low_pwr(low_pwr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  // register file environment
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) mem[i] <= 8'h00;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  // reference history of supply flags
  always @(posedge clk) begin
    if (!rst_n) begin
      vb_q.delete();
      vl_q.delete();
    end else begin
      vb_q.push_front(vbat);
      vl_q.push_front(vlow);
      if (vb_q.size() > 3) begin
        void'(vb_q.pop_back());
        void'(vl_q.pop_back());
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  // per-clock comparison against the flag history (R9, R6, R7)
  always @(negedge clk) begin
    if (rst_n && !done && vb_q.size() == 3) begin
      chk(sel_bat == vb_q[2], "R9 sel_bat", sel_bat, vb_q[2]);
      chk(low_pwr == (vb_q[2] & vl_q[2]), "R9 low_pwr", low_pwr, vb_q[2] & vl_q[2]);
      if (vl_q[2]) chk(!sda_oe && !reg_we, "R7 quiet while failed", {sda_oe, reg_we}, 0);
    end
  end

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; wq(); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq();
  endtask

  task automatic recv_bit(output bit b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    ack = !a;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit m_ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(!m_ack);
  endtask

  task automatic check_mem(input string tag);
    for (int i = 0; i < NR; i++) chk(mem[i] == exp_mem[i], tag, mem[i], exp_mem[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] rd;
    for (int i = 0; i < NR; i++) exp_mem[i] = 8'h00;
    wq(10);
    rst_n = 1'b1;
    wq(2);
    chk(sda_oe == 1'b0, "R9 reset sda_oe", sda_oe, 0);
    chk(sel_bat == 1'b0 && low_pwr == 1'b0, "R9 reset supply outputs", {sel_bat, low_pwr}, 0);

    // R8: recovery interval after reset hides the bus
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk(!ack, "R8 address during reset recovery", ack, 0);
    bus_stop();
    wq(100);

    // R3/R4: write burst with pointer load
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R3 own address ack", ack, 1);
    send_byte(8'h02, ack);       chk(ack, "R4 pointer byte ack", ack, 1);
    send_byte(8'hA5, ack);       chk(ack, "R4 data ack", ack, 1);
    send_byte(8'h3C, ack);       chk(ack, "R4 data ack", ack, 1);
    bus_stop();
    exp_mem[2] = 8'hA5; exp_mem[3] = 8'h3C;
    check_mem("R4 burst write");

    // R5/R2: read after repeated start, master nack releases
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h02, ack);
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R5 read address ack", ack, 1);
    recv_byte(rd, 1'b1); chk(rd == 8'hA5, "R2 R5 first read byte", rd, 8'hA5);
    recv_byte(rd, 1'b0); chk(rd == 8'h3C, "R5 second read byte", rd, 8'h3C);
    recv_byte(rd, 1'b0); chk(rd == 8'hFF, "R5 released after nack", rd, 8'hFF);
    bus_stop();

    // R3: foreign address
    bus_start();
    send_byte({7'h50, 1'b0}, ack); chk(!ack, "R3 foreign address nack", ack, 0);
    send_byte(8'h04, ack);         chk(!ack, "R3 silent after foreign address", ack, 0);
    send_byte(8'h99, ack);
    bus_stop();
    check_mem("R3 no write for foreign address");

    // R1: clocking without a start
    send_byte({DEV, 1'b0}, ack); chk(!ack, "R1 no start no ack", ack, 0);
    send_byte(8'h01, ack);
    send_byte(8'h66, ack);
    check_mem("R1 no write without start");

    // R4: wrap at top location
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h07, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    bus_stop();
    exp_mem[7] = 8'h11; exp_mem[0] = 8'h22;
    check_mem("R4 wrap write");
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    recv_byte(rd, 1'b0); chk(rd == exp_mem[1], "R4 R5 pointer after wrap", rd, exp_mem[1]);
    bus_stop();

    // R6/R7: power fail mid-byte
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h05, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    vlow = 1'b1;
    wq(4);
    chk(sda_oe == 1'b0, "R6 released on power fail", sda_oe, 0);
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(!ack, "R7 ignored while failed", ack, 0);
    send_byte(8'h06, ack);
    send_byte(8'h77, ack);
    bus_stop();
    vlow = 1'b0;
    wq(4);
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(!ack, "R7 ignored during recovery", ack, 0);
    bus_stop();
    check_mem("R6 R7 no write across power fail");
    wq(100);
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R8 bus back after recovery", ack, 1);
    recv_byte(rd, 1'b0); chk(rd == exp_mem[0], "R6 pointer reset to zero", rd, exp_mem[0]);
    bus_stop();

    // R8: short re-assertion restarts the count
    vlow = 1'b1; wq(5);
    vlow = 1'b0; wq(40);
    vlow = 1'b1; wq(3);
    vlow = 1'b0; wq(22);
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(!ack, "R8 count restarted", ack, 0);
    bus_stop();
    wq(100);
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R8 accepted after full interval", ack, 1);
    bus_stop();

    // R9: battery switch-over and return
    vlow = 1'b1; vbat = 1'b1; wq(10);
    chk(sel_bat == 1'b1, "R9 battery selected", sel_bat, 1);
    chk(low_pwr == 1'b1, "R9 low power raised", low_pwr, 1);
    vbat = 1'b0; wq(10);
    chk(sel_bat == 1'b0, "R9 main supply back", sel_bat, 0);
    chk(low_pwr == 1'b0, "R9 low power cleared", low_pwr, 0);
    vlow = 1'b0; wq(10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule